// File: doc/BRIEF.md
# Stack-Based Subroutine Call/Return Sequencer

This block carries out subroutine entry and exit using a stack kept in ordinary memory. It holds a program counter, a stack pointer and two staging registers: one for the memory address and one for the memory data. Every memory access goes through these two staging registers. A one-cycle request pulse starts an operation. The request carries a select bit that picks call or return, and a 26-bit jump target that is used only for a call.

A call runs five fixed steps:
1. Lower the stack pointer by one word.
2. Stage the stack pointer as the memory address.
3. Stage the current program counter as the write data.
4. Write the staged data to memory.
5. Load the program counter from the target.

A return runs four fixed steps:
1. Stage the stack pointer as the memory address.
2. Read memory into the data staging register.
3. Load the program counter from the staged data.
4. Raise the stack pointer by one word.

A done pulse marks the last step of each operation. The block drives one memory port, with separate read and write strobes. Read data must be valid in the same cycle as the read strobe, so the memory answers within one cycle.

Top module: `stk_call_seq`

## Requirements
- R1: After reset, pc_o is 0 and sp_o equals the parameter SP_TOP (default 0x100). busy_o, done_o, mem_rd_o and mem_wr_o are all low.
- R2: A call lowers sp_o by 4. The single memory write of the call then goes to the lowered stack pointer value.
- R3: The data written by a call equals the pc_o value that was held before the call began.
- R4: At the end of a call, pc_o equals the 26-bit target, zero-extended to 32 bits.
- R5: A return issues one read at the current sp_o. At the end of the return, pc_o equals the word read from that address.
- R6: A return raises sp_o by 4 in its final step. That step comes after the read.
- R7: When start_i is sampled high while idle, busy_o is high for exactly 5 cycles on a call (is_ret_i=0) and exactly 4 cycles on a return (is_ret_i=1). done_o is high for one cycle only: the last busy cycle.
- R8: A start_i pulse seen while busy_o is high is ignored. The running operation completes unchanged, and no second operation follows it.
- R9: mem_rd_o and mem_wr_o are never high in the same cycle. A call gives exactly one write strobe and no read. A return gives exactly one read strobe and no write.
- R10: While idle with start_i low, pc_o and sp_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Request pulse, accepted only while idle |
| is_ret_i | input | 1 | 0 selects call, 1 selects return |
| target_i | input | 26 | Call destination, zero-extended into the program counter |
| mem_addr_o | output | 32 | Memory byte address, taken from the address staging register |
| mem_wdata_o | output | 32 | Memory write data, taken from the data staging register |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rdata_i | input | 32 | Memory read data, valid in the read strobe cycle |
| busy_o | output | 1 | High while an operation is running |
| done_o | output | 1 | One-cycle pulse on the final step |
| pc_o | output | 32 | Program counter |
| sp_o | output | 32 | Stack pointer |

## Verification
The assertions check several properties on every cycle:
- Read and write strobes are never active together.
- done_o lasts a single cycle and only occurs while busy_o is high.
- Any memory strobe addresses the current stack pointer.
- An operation never ends before its done step.
- The two architectural registers stay frozen while the block is idle.

Some behaviours can only be shown by the bench's scenarios, because they need a reference stack model:
- Nested calls push the right return addresses.
- Returns pop values written by earlier calls.
- The target is zero-extended.
- Steps are counted exactly per operation.
- A mid-operation request is ignored.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_C_DEC,
    ST_C_MAR,
    ST_C_MDR,
    ST_C_WR,
    ST_C_JMP,
    ST_R_MAR,
    ST_R_RD,
    ST_R_PC,
    ST_R_INC
  } step_e;

  typedef struct packed {
    logic sp_dec;
    logic sp_inc;
    logic mar_ld;
    logic mdr_ld;
    logic mdr_sel_mem;
    logic pc_ld;
    logic pc_sel_mdr;
    logic mem_rd;
    logic mem_wr;
    logic done;
  } xfer_t;

endpackage

// File: rtl/stkseq_rst_sync.sv
module stkseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/stkseq_ctrl.sv
module stkseq_ctrl
  import stkseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start_i,
  input  logic  is_ret_i,
  output logic  accept_o,
  output logic  busy_o,
  output xfer_t xfer_o
);
  step_e state_q, state_d;

  assign accept_o = start_i && (state_q == ST_IDLE);
  assign busy_o   = (state_q != ST_IDLE);

  // next-state process
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_o) state_d = is_ret_i ? ST_R_MAR : ST_C_DEC;
      ST_C_DEC: state_d = ST_C_MAR;
      ST_C_MAR: state_d = ST_C_MDR;
      ST_C_MDR: state_d = ST_C_WR;
      ST_C_WR:  state_d = ST_C_JMP;
      ST_C_JMP: state_d = ST_IDLE;
      ST_R_MAR: state_d = ST_R_RD;
      ST_R_RD:  state_d = ST_R_PC;
      ST_R_PC:  state_d = ST_R_INC;
      ST_R_INC: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // per-step transfer decode
  always_comb begin
    xfer_o = '0;
    unique case (state_q)
      ST_C_DEC: xfer_o.sp_dec = 1'b1;
      ST_C_MAR: xfer_o.mar_ld = 1'b1;
      ST_C_MDR: xfer_o.mdr_ld = 1'b1;
      ST_C_WR:  xfer_o.mem_wr = 1'b1;
      ST_C_JMP: begin
        xfer_o.pc_ld = 1'b1;
        xfer_o.done  = 1'b1;
      end
      ST_R_MAR: xfer_o.mar_ld = 1'b1;
      ST_R_RD: begin
        xfer_o.mem_rd      = 1'b1;
        xfer_o.mdr_ld      = 1'b1;
        xfer_o.mdr_sel_mem = 1'b1;
      end
      ST_R_PC: begin
        xfer_o.pc_ld      = 1'b1;
        xfer_o.pc_sel_mdr = 1'b1;
      end
      ST_R_INC: begin
        xfer_o.sp_inc = 1'b1;
        xfer_o.done   = 1'b1;
      end
      default: xfer_o = '0;
    endcase
  end
endmodule

// File: rtl/stkseq_regs.sv
module stkseq_regs
  import stkseq_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              TGT_W      = 26,
  parameter int              WORD_BYTES = 4,
  parameter logic [ADDR_W-1:0] SP_TOP   = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic [TGT_W-1:0]  target_i,
  input  xfer_t             xfer_i,
  input  logic [ADDR_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] mar_o,
  output logic [ADDR_W-1:0] mdr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o
);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(WORD_BYTES);
  localparam int                PAD_W = ADDR_W - TGT_W;

  logic [ADDR_W-1:0] sp_q, sp_d, pc_q, pc_d, mar_q, mdr_q, mdr_d;
  logic [TGT_W-1:0]  tgt_q;
  logic              sp_en, pc_en;

  // next-value process
  always_comb begin
    sp_en = xfer_i.sp_dec || xfer_i.sp_inc;
    sp_d  = xfer_i.sp_dec ? (sp_q - STEP) : (sp_q + STEP);
    pc_en = xfer_i.pc_ld;
    pc_d  = xfer_i.pc_sel_mdr ? mdr_q : {{PAD_W{1'b0}}, tgt_q};
    mdr_d = xfer_i.mdr_sel_mem ? rdata_i : pc_q;
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= SP_TOP;
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      tgt_q <= '0;
    end else begin
      if (sp_en)         sp_q  <= sp_d;
      if (pc_en)         pc_q  <= pc_d;
      if (xfer_i.mar_ld) mar_q <= sp_q;
      if (xfer_i.mdr_ld) mdr_q <= mdr_d;
      if (accept_i)      tgt_q <= target_i;
    end
  end

  assign mar_o = mar_q;
  assign mdr_o = mdr_q;
  assign pc_o  = pc_q;
  assign sp_o  = sp_q;
endmodule

// File: rtl/stk_call_seq.sv
module stk_call_seq
  import stkseq_pkg::*;
#(
  parameter int              ADDR_W     = 32,
  parameter int              TGT_W      = 26,
  parameter int              WORD_BYTES = 4,
  parameter int              SYNC_STG   = 2,
  parameter logic [ADDR_W-1:0] SP_TOP   = 'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              is_ret_i,
  input  logic [TGT_W-1:0]  target_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [ADDR_W-1:0] mem_wdata_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o
);
  logic  rst_n_sync;
  logic  accept;
  xfer_t xfer;

  stkseq_rst_sync #(.STAGES(SYNC_STG)) i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  stkseq_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .start_i  (start_i),
    .is_ret_i (is_ret_i),
    .accept_o (accept),
    .busy_o   (busy_o),
    .xfer_o   (xfer)
  );

  stkseq_regs #(
    .ADDR_W     (ADDR_W),
    .TGT_W      (TGT_W),
    .WORD_BYTES (WORD_BYTES),
    .SP_TOP     (SP_TOP)
  ) i_regs (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .accept_i (accept),
    .target_i (target_i),
    .xfer_i   (xfer),
    .rdata_i  (mem_rdata_i),
    .mar_o    (mem_addr_o),
    .mdr_o    (mem_wdata_o),
    .pc_o     (pc_o),
    .sp_o     (sp_o)
  );

  assign mem_rd_o = xfer.mem_rd;
  assign mem_wr_o = xfer.mem_wr;
  assign done_o   = xfer.done;
endmodule

// File: rtl/stkseq_chk.sv
module stkseq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic [ADDR_W-1:0] pc_o
);
  // R9
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);

  // R7
  no_early_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  // R2
  wr_at_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (mem_addr_o == sp_o));

  // R5
  rd_at_sp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (mem_addr_o == sp_o));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(pc_o) && $stable(sp_o)));
endmodule

bind stk_call_seq stkseq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_rd_o   (mem_rd_o),
  .mem_wr_o   (mem_wr_o),
  .mem_addr_o (mem_addr_o),
  .sp_o       (sp_o),
  .pc_o       (pc_o)
);

// File: tb/test_stk_call_seq.sv
`timescale 1ns/1ps
module test_stk_call_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        is_ret_i = 1'b0;
  logic [25:0] target_i = '0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, pc_o, sp_o;
  logic        mem_rd_o, mem_wr_o, busy_o, done_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  stk_call_seq i_stk_call_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_ret_i(is_ret_i),
    .target_i(target_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .sp_o(sp_o)
  );

  // memory model: 64 words, answers within the strobe cycle
  logic [31:0] mem [64];
  assign mem_rdata_i = mem[mem_addr_o[7:2]];

  int          wr_tot = 0, rd_tot = 0;
  logic [31:0] last_wa = '0, last_wd = '0, last_ra = '0;
  always @(posedge clk) begin
    if (mem_wr_o) begin
      mem[mem_addr_o[7:2]] <= mem_wdata_o;
      wr_tot  <= wr_tot + 1;
      last_wa <= mem_addr_o;
      last_wd <= mem_wdata_o;
    end
    if (mem_rd_o) begin
      rd_tot  <= rd_tot + 1;
      last_ra <= mem_addr_o;
    end
  end

  // reference model
  logic [31:0] m_pc, m_sp;
  logic [31:0] m_mem [64];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // runs one operation; poke raises a conflicting start in the second busy cycle
  task automatic run_op(input logic ret, input logic [25:0] tgt, input bit poke);
    int cyc = 0, dones = 0, wr0, rd0;
    logic dlast = 1'b0;
    logic [31:0] old_pc = m_pc;
    @(negedge clk);
    wr0 = wr_tot; rd0 = rd_tot;
    start_i = 1'b1; is_ret_i = ret; target_i = tgt;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o && cyc < 50) begin
      if (poke && cyc == 1) begin
        start_i = 1'b1; is_ret_i = ~ret; target_i = ~tgt;
      end else begin
        start_i = 1'b0;
      end
      cyc++;
      dones += int'(done_o);
      dlast = done_o;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (!ret) begin
      m_sp = m_sp - 32'd4;
      m_mem[m_sp[7:2]] = old_pc;
      m_pc = {6'd0, tgt};
      chk("R7 call busy cycles", cyc, 5);
      chk("R9 call write count", wr_tot - wr0, 1);
      chk("R9 call read count", rd_tot - rd0, 0);
      chk("R2 push address", last_wa, m_sp);
      chk("R3 pushed return address", last_wd, old_pc);
      chk("R4 pc after call", pc_o, m_pc);
      chk("R2 sp after call", sp_o, m_sp);
    end else begin
      chk("R5 pop address", last_ra, m_sp);
      m_pc = m_mem[m_sp[7:2]];
      m_sp = m_sp + 32'd4;
      chk("R7 return busy cycles", cyc, 4);
      chk("R9 return read count", rd_tot - rd0, 1);
      chk("R9 return write count", wr_tot - wr0, 0);
      chk("R5 pc after return", pc_o, m_pc);
      chk("R6 sp after return", sp_o, m_sp);
    end
    chk("R7 single done pulse", dones, 1);
    chk("R7 done on final step", 32'(dlast), 1);
  endtask

  // stimulus table: {is_ret, target}
  localparam logic [26:0] VEC [12] = '{
    {1'b0, 26'h0000010}, {1'b0, 26'h0000200}, {1'b0, 26'h0003004},
    {1'b1, 26'h0},       {1'b1, 26'h0},       {1'b0, 26'h3FFFFFF},
    {1'b1, 26'h0},       {1'b1, 26'h0},       {1'b0, 26'h0000155},
    {1'b0, 26'h2AAAAAA}, {1'b1, 26'h0},       {1'b1, 26'h0}
  };

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog R7 actual=hung expected=finished");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = '0;
      m_mem[i] = '0;
    end
    m_pc = '0;
    m_sp = 32'h100;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 pc reset", pc_o, 0);
    chk("R1 sp reset", sp_o, 32'h100);
    chk("R1 busy reset", 32'(busy_o), 0);
    chk("R1 done reset", 32'(done_o), 0);
    chk("R1 strobes reset", 32'({mem_rd_o, mem_wr_o}), 0);

    // R10 idle hold
    repeat (3) @(negedge clk);
    chk("R10 pc idle", pc_o, 0);
    chk("R10 sp idle", sp_o, 32'h100);

    for (int i = 0; i < 12; i++) run_op(VEC[i][26], VEC[i][25:0], 1'b0);

    // R8 conflicting start while busy: call with poke
    run_op(1'b0, 26'h0000ABC, 1'b1);
    @(negedge clk);
    chk("R8 no second op after poke", 32'(busy_o), 0);
    chk("R8 pc kept after poke", pc_o, 32'h0000_0ABC);
    // R8 poke during return
    run_op(1'b1, 26'h0, 1'b1);
    @(negedge clk);
    chk("R8 no second op after return poke", 32'(busy_o), 0);
    chk("R8 sp after return poke", sp_o, 32'h100);

    // R4 upper bits cleared after a full-width target
    run_op(1'b0, 26'h3FFFFFF, 1'b0);
    chk("R4 zero-extended top bits", {26'd0, pc_o[31:26]}, 0);
    run_op(1'b1, 26'h0, 1'b0);

    // R10 idle hold after operations
    repeat (3) @(negedge clk);
    chk("R10 pc hold after ops", pc_o, m_pc);
    chk("R10 sp hold after ops", sp_o, m_sp);

    finish_up();
  end
endmodule